// File: doc/BRIEF.md
# Chunked Variable-Length Trace Encoder

This block turns one load-trace request into a compact bit message and pushes it out through a narrow trace port. A request carries four fields: a clock-cycle delta since the previous message, the number of the core that issued the load, a count of cache hits that were not reported, and the loaded data word. The two counters are usually small. Each counter is therefore cut into chunks, starting with the least significant chunk. Every chunk is followed by a flag bit that says whether more chunks come. The core number and the data word travel at fixed widths.

Two chunk layouts exist. In the uniform layout every counter chunk is one byte wide. In the compact layout the delta starts with a 4-bit chunk and continues in 2-bit chunks, and the hit count uses 2-bit chunks throughout. A configuration pin picks the layout and is captured while reset is held. After acceptance the message is shifted out as fixed-width slices, one per clock. The request side stays closed until the final slice has gone.

Top module: `trc_varlen_packer`

## Requirements
- R1: The message stream starts at bit 0 of the first slice. Stream bit `s*PORT_W+j` is `out_data[j]` of slice `s`. Fields follow in this order: clock delta, core number, hit count, data word. Every field is sent least significant bit first.
- R2: The core number field is `ceil(log2 N_CORES)` bits wide. With the default of 4 cores it is 2 bits.
- R3: In uniform layout (`cfg_var_mode`=0), each counter is sent as 8-bit chunks, least significant chunk first, and each chunk is followed by one flag bit.
- R4: In compact layout (`cfg_var_mode`=1), the clock delta is sent as a 4-bit first chunk followed by 2-bit chunks, each chunk followed by one flag bit.
- R5: In compact layout, the hit count is sent as 2-bit chunks, each chunk followed by one flag bit.
- R6: A flag bit of 1 means another chunk of the same counter follows, and 0 marks the final chunk. A counter of value zero still sends exactly one chunk, with flag 0.
- R7: Each counter sends the fewest chunks that cover its highest set bit. The message length is the sum of the two counter code lengths, the core field width and `LV_W`.
- R8: The data word is sent unchanged at `LV_W` bits (32 by default) as the last field.
- R9: The layout is captured from `cfg_var_mode` on clock edges while `rst_n` is low. Later changes on that pin have no effect until the next reset.
- R10: After a request is accepted, `out_valid` is high from the next cycle for exactly `ceil(length/PORT_W)` consecutive cycles, one slice per cycle. `out_last` marks the final slice. Stream bits beyond the message length are zero.
- R11: `req_ready` is high after reset and whenever no message is in flight. It is low from acceptance until the cycle after the final slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk for layout capture |
| cfg_var_mode | input | 1 | Layout select captured during reset: 0 uniform, 1 compact |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The encoder can accept a request |
| req_dcc | input | DCC_W (16) | Clock-cycle delta |
| req_core | input | ceil(log2 N_CORES) (2) | Issuing core number |
| req_skip | input | SKIP_W (16) | Unreported hit count |
| req_lv | input | LV_W (32) | Load data word |
| out_valid | output | 1 | A slice is present on out_data |
| out_data | output | PORT_W (8) | Current message slice, lower bit earlier in the stream |
| out_last | output | 1 | The current slice ends the message |

## Verification
The bench goes after the chunk-count boundaries: delta values 255/256 in uniform layout and 15/16 in compact layout, and hit counts 3/4. An encoder that drops the top chunk or adds a spare one at these points shifts every later field, so the decoded core number and data word no longer match. Zero-valued counters check that one chunk with a cleared flag is still sent. All-ones counters check the longest message, where a wrong slice count or missing zero padding shows up in the final slice. A layout pin changed after reset must leave the stream decodable under the captured layout. A design that followed the pin live would produce fields the bench cannot reconstruct.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic {
        LAYOUT_UNIFORM = 1'b0,
        LAYOUT_COMPACT = 1'b1
    } trc_layout_e;

    // number of chunks needed to hold a value of vw bits
    function automatic int unsigned chunk_count(input int unsigned vw,
                                                input int unsigned fw,
                                                input int unsigned nw);
        if (vw <= fw) return 1;
        return 1 + (vw - fw + nw - 1) / nw;
    endfunction

    // longest code a counter can produce, flag bits included
    function automatic int unsigned coded_max(input int unsigned vw,
                                              input int unsigned fw,
                                              input int unsigned nw);
        return fw + 1 + (chunk_count(vw, fw, nw) - 1) * (nw + 1);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trc_chunk_coder.sv
module trc_chunk_coder #(
    parameter int unsigned VAL_W   = 16,
    parameter int unsigned FIRST_W = 8,
    parameter int unsigned NEXT_W  = 8,
    parameter int unsigned OUT_W   = 24,
    parameter int unsigned LEN_W   = 7
) (
    input  logic [VAL_W-1:0] value,
    output logic [OUT_W-1:0] code,
    output logic [LEN_W-1:0] len
);
    localparam int unsigned N_CH   = trc_pkg::chunk_count(VAL_W, FIRST_W, NEXT_W);
    localparam int unsigned CAP    = FIRST_W + (N_CH - 1) * NEXT_W;
    localparam int unsigned CODE_W = trc_pkg::coded_max(VAL_W, FIRST_W, NEXT_W);

    logic [CAP-1:0]    padded;
    logic [N_CH:0]     live;
    logic [CODE_W-1:0] raw;

    assign padded     = CAP'(value);
    assign live[0]    = 1'b1;
    assign live[N_CH] = 1'b0;

    // a chunk is sent when any bit at or above its start is set
    for (genvar k = 1; k < N_CH; k++) begin : g_live
        localparam int unsigned START = FIRST_W + (k - 1) * NEXT_W;
        assign live[k] = |padded[CAP-1:START];
    end

    for (genvar k = 0; k < N_CH; k++) begin : g_chunk
        localparam int unsigned W   = (k == 0) ? FIRST_W : NEXT_W;
        localparam int unsigned SRC = (k == 0) ? 0 : FIRST_W + (k - 1) * NEXT_W;
        localparam int unsigned DST = (k == 0) ? 0 : FIRST_W + 1 + (k - 1) * (NEXT_W + 1);
        assign raw[DST +: W] = padded[SRC +: W];
        assign raw[DST + W]  = live[k + 1];
    end

    always_comb begin
        len = LEN_W'(FIRST_W + 1);
        for (int k = 1; k < N_CH; k++) begin
            if (live[k]) len = len + LEN_W'(NEXT_W + 1);
        end
    end

    assign code = OUT_W'(raw);

endmodule

// File: rtl/trc_msg_packer.sv
module trc_msg_packer #(
    parameter int unsigned DCC_W    = 16,
    parameter int unsigned SKIP_W   = 16,
    parameter int unsigned CORE_W   = 2,
    parameter int unsigned LV_W     = 32,
    parameter int unsigned UNI_W    = 8,
    parameter int unsigned CD_FIRST = 4,
    parameter int unsigned CD_NEXT  = 2,
    parameter int unsigned CS_FIRST = 2,
    parameter int unsigned CS_NEXT  = 2,
    parameter int unsigned DCC_MAX  = 23,
    parameter int unsigned SKIP_MAX = 24,
    parameter int unsigned MSG_W    = 81,
    parameter int unsigned LEN_W    = 7
) (
    input  trc_pkg::trc_layout_e layout,
    input  logic [DCC_W-1:0]     dcc,
    input  logic [CORE_W-1:0]    core,
    input  logic [SKIP_W-1:0]    skip,
    input  logic [LV_W-1:0]      lv,
    output logic [MSG_W-1:0]     msg,
    output logic [LEN_W-1:0]     msg_len
);
    logic [DCC_MAX-1:0]  dcc_code_u, dcc_code_c, dcc_code;
    logic [SKIP_MAX-1:0] skip_code_u, skip_code_c, skip_code;
    logic [LEN_W-1:0]    dcc_len_u, dcc_len_c, dcc_len;
    logic [LEN_W-1:0]    skip_len_u, skip_len_c, skip_len;

    trc_chunk_coder #(.VAL_W(DCC_W), .FIRST_W(UNI_W), .NEXT_W(UNI_W),
                      .OUT_W(DCC_MAX), .LEN_W(LEN_W))
        u_dcc_uni (.value(dcc), .code(dcc_code_u), .len(dcc_len_u));

    trc_chunk_coder #(.VAL_W(DCC_W), .FIRST_W(CD_FIRST), .NEXT_W(CD_NEXT),
                      .OUT_W(DCC_MAX), .LEN_W(LEN_W))
        u_dcc_cmp (.value(dcc), .code(dcc_code_c), .len(dcc_len_c));

    trc_chunk_coder #(.VAL_W(SKIP_W), .FIRST_W(UNI_W), .NEXT_W(UNI_W),
                      .OUT_W(SKIP_MAX), .LEN_W(LEN_W))
        u_skip_uni (.value(skip), .code(skip_code_u), .len(skip_len_u));

    trc_chunk_coder #(.VAL_W(SKIP_W), .FIRST_W(CS_FIRST), .NEXT_W(CS_NEXT),
                      .OUT_W(SKIP_MAX), .LEN_W(LEN_W))
        u_skip_cmp (.value(skip), .code(skip_code_c), .len(skip_len_c));

    always_comb begin
        if (layout == trc_pkg::LAYOUT_COMPACT) begin
            dcc_code  = dcc_code_c;
            dcc_len   = dcc_len_c;
            skip_code = skip_code_c;
            skip_len  = skip_len_c;
        end else begin
            dcc_code  = dcc_code_u;
            dcc_len   = dcc_len_u;
            skip_code = skip_code_u;
            skip_len  = skip_len_u;
        end
    end

    // fields laid out back to back, first field at bit 0
    always_comb begin
        msg = MSG_W'(dcc_code);
        msg = msg | (MSG_W'(core) << dcc_len);
        msg = msg | (MSG_W'(skip_code) << (dcc_len + LEN_W'(CORE_W)));
        msg = msg | (MSG_W'(lv) << (dcc_len + LEN_W'(CORE_W) + skip_len));
        msg_len = dcc_len + LEN_W'(CORE_W) + skip_len + LEN_W'(LV_W);
    end

endmodule

// File: rtl/trc_slice_shifter.sv
module trc_slice_shifter #(
    parameter int unsigned MSG_W  = 81,
    parameter int unsigned LEN_W  = 7,
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MSG_W-1:0]  msg,
    input  logic [LEN_W-1:0]  msg_len,
    output logic              busy,
    output logic [PORT_W-1:0] slice,
    output logic              last
);
    localparam int unsigned N_SL  = (MSG_W + PORT_W - 1) / PORT_W;
    localparam int unsigned BUF_W = N_SL * PORT_W;
    localparam int unsigned CNT_W = $clog2(N_SL + 1);

    typedef struct packed {
        logic             busy;
        logic [BUF_W-1:0] sh;
        logic [CNT_W-1:0] left;
    } ser_t;

    ser_t st_d, st_q;
    logic [CNT_W-1:0] slices_need;

    assign slices_need = CNT_W'((32'(msg_len) + PORT_W - 1) / PORT_W);

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.sh   = st_q.sh >> PORT_W;
            st_d.left = st_q.left - 1'b1;
            if (st_q.left == CNT_W'(1)) st_d.busy = 1'b0;
        end else if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = BUF_W'(msg);
            st_d.left = slices_need;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign slice = st_q.sh[PORT_W-1:0];
    assign last  = st_q.busy && (st_q.left == CNT_W'(1));

endmodule

// File: rtl/trc_varlen_packer.sv
module trc_varlen_packer #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned DCC_W    = 16,
    parameter int unsigned SKIP_W   = 16,
    parameter int unsigned LV_W     = 32,
    parameter int unsigned PORT_W   = 8,
    parameter int unsigned UNI_W    = 8,
    parameter int unsigned CD_FIRST = 4,
    parameter int unsigned CD_NEXT  = 2,
    parameter int unsigned CS_FIRST = 2,
    parameter int unsigned CS_NEXT  = 2,
    localparam int unsigned CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_var_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DCC_W-1:0]  req_dcc,
    input  logic [CORE_W-1:0] req_core,
    input  logic [SKIP_W-1:0] req_skip,
    input  logic [LV_W-1:0]   req_lv,
    output logic              out_valid,
    output logic [PORT_W-1:0] out_data,
    output logic              out_last
);
    import trc_pkg::*;

    localparam int unsigned DCC_MAX  = umax(coded_max(DCC_W, UNI_W, UNI_W),
                                            coded_max(DCC_W, CD_FIRST, CD_NEXT));
    localparam int unsigned SKIP_MAX = umax(coded_max(SKIP_W, UNI_W, UNI_W),
                                            coded_max(SKIP_W, CS_FIRST, CS_NEXT));
    localparam int unsigned MSG_W    = DCC_MAX + CORE_W + SKIP_MAX + LV_W;
    localparam int unsigned LEN_W    = $clog2(MSG_W + 1);

    trc_layout_e      mode_d, mode_q;
    logic [MSG_W-1:0] msg;
    logic [LEN_W-1:0] msg_len;
    logic             ser_busy;
    logic             accept;

    // layout follows the pin only while reset is held
    always_comb begin
        mode_d = mode_q;
        if (!rst_n) mode_d = trc_layout_e'(cfg_var_mode);
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    trc_msg_packer #(
        .DCC_W(DCC_W), .SKIP_W(SKIP_W), .CORE_W(CORE_W), .LV_W(LV_W),
        .UNI_W(UNI_W), .CD_FIRST(CD_FIRST), .CD_NEXT(CD_NEXT),
        .CS_FIRST(CS_FIRST), .CS_NEXT(CS_NEXT),
        .DCC_MAX(DCC_MAX), .SKIP_MAX(SKIP_MAX), .MSG_W(MSG_W), .LEN_W(LEN_W)
    ) u_pack (
        .layout (mode_q),
        .dcc    (req_dcc),
        .core   (req_core),
        .skip   (req_skip),
        .lv     (req_lv),
        .msg    (msg),
        .msg_len(msg_len)
    );

    assign req_ready = !ser_busy;
    assign accept    = req_valid && req_ready;

    trc_slice_shifter #(.MSG_W(MSG_W), .LEN_W(LEN_W), .PORT_W(PORT_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .msg    (msg),
        .msg_len(msg_len),
        .busy   (ser_busy),
        .slice  (out_data),
        .last   (out_last)
    );

    assign out_valid = ser_busy;

endmodule

// File: rtl/trc_varlen_packer_chk.sv
module trc_varlen_packer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic out_valid,
    input logic out_last,
    input logic mode_q
);
    // R11
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R10
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);

    // R10
    last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R11
    last_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (!out_valid && req_ready));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));

endmodule

bind trc_varlen_packer trc_varlen_packer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .out_valid(out_valid),
    .out_last (out_last),
    .mode_q   (mode_q)
);

// File: tb/trc_varlen_packer_tb.sv
module trc_varlen_packer_tb;
    localparam int PW = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_var_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [15:0]   req_dcc = '0;
    logic [CW-1:0] req_core = '0;
    logic [15:0]   req_skip = '0;
    logic [31:0]   req_lv = '0;
    logic          out_valid;
    logic [PW-1:0] out_data;
    logic          out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit compact = 1'b0;
    logic [255:0] cap;

    always #5 clk = ~clk;

    trc_varlen_packer #(.N_CORES(4), .DCC_W(16), .SKIP_W(16), .LV_W(32), .PORT_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_var_mode(cfg_var_mode),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dcc(req_dcc), .req_core(req_core), .req_skip(req_skip), .req_lv(req_lv),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 100000);
            report();
            $finish;
        end
    end

    function automatic int code_len(input longint unsigned v, input int fw, input int nw);
        int n = 1;
        int cov = fw;
        while ((v >> cov) != 0) begin
            n++;
            cov += nw;
        end
        return fw + 1 + (n - 1) * (nw + 1);
    endfunction

    function automatic longint unsigned take_count(inout int pos, input int fw, input int nw);
        longint unsigned val = 0;
        int sh = 0;
        int w = fw;
        bit more = 1'b1;
        for (int c = 0; c < 12 && more; c++) begin
            for (int i = 0; i < w; i++) val |= longint'(cap[pos + i]) << (sh + i);
            pos += w;
            more = cap[pos];
            pos++;
            sh += w;
            w = nw;
        end
        return val;
    endfunction

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        cfg_var_mode = mode;
        compact = mode;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 ready after reset, R10 nothing on the port
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
        chk(out_valid == 1'b0, "R10", "idle port after reset", out_valid, 0);
    endtask

    task automatic send_chk(input logic [15:0] dcc, input logic [CW-1:0] core,
                            input logic [15:0] skip, input logic [31:0] lv);
        int nsl = 0;
        int pos = 0;
        int dfw, dnw, sfw, snw, exp_len, exp_sl;
        longint unsigned got;
        string rd, rs;
        dfw = compact ? 4 : 8; dnw = compact ? 2 : 8;
        sfw = compact ? 2 : 8; snw = compact ? 2 : 8;
        rd = compact ? "R4" : "R3";
        rs = compact ? "R5" : "R3";
        exp_len = code_len(dcc, dfw, dnw) + CW + code_len(skip, sfw, snw) + 32;
        exp_sl = (exp_len + PW - 1) / PW;

        chk(req_ready == 1'b1, "R11", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_dcc = dcc; req_core = core; req_skip = skip; req_lv = lv;
        @(negedge clk);
        req_valid = 1'b0;
        cap = '0;
        chk(out_valid == 1'b1, "R10", "slice after accept", out_valid, 1);
        chk(req_ready == 1'b0, "R11", "ready low in flight", req_ready, 0);
        while (out_valid && nsl < 30) begin
            cap[nsl * PW +: PW] = out_data;
            nsl++;
            if (out_last) break;
            @(negedge clk);
        end
        chk(nsl == exp_sl, "R10", "slice count", nsl, exp_sl);
        @(negedge clk);
        chk(!out_valid && req_ready, "R11", "port free after last", {out_valid, req_ready}, 2'b01);

        // R6 flag after first delta chunk
        chk(cap[dfw] == ((longint'(dcc) >> dfw) != 0), "R6", "first delta flag",
            cap[dfw], (longint'(dcc) >> dfw) != 0);
        got = take_count(pos, dfw, dnw);
        chk(got == dcc, rd, "delta field", got, dcc);
        chk(pos == code_len(dcc, dfw, dnw), "R7", "delta code length", pos, code_len(dcc, dfw, dnw));
        got = cap[pos +: CW];
        chk(got == core, "R2", "core field", got, core);
        pos += CW;
        got = take_count(pos, sfw, snw);
        chk(got == skip, rs, "hit count field", got, skip);
        got = cap[pos +: 32];
        chk(got == lv, "R8", "data word field R1 order", got, lv);
        pos += 32;
        chk(pos == exp_len, "R7", "message length", pos, exp_len);
        got = 0;
        for (int i = pos; i < 256; i++) got |= longint'(cap[i]);
        chk(got == 0, "R10", "zero padding", got, 0);
    endtask

    task automatic t_uniform();
        do_reset(1'b0);
        send_chk(16'h0000, 2'd0, 16'h0000, 32'h0000_0000);  // R6 zero values
        send_chk(16'h0012, 2'd3, 16'h0005, 32'hDEAD_BEEF);  // R3 R1
        send_chk(16'h00FF, 2'd1, 16'h0100, 32'h1234_5678);  // R7 255 and 256
        send_chk(16'h0100, 2'd2, 16'h00FF, 32'h8000_0001);  // R7 swapped
        send_chk(16'hFFFF, 2'd3, 16'hFFFF, 32'hFFFF_FFFF);  // R3 longest
    endtask

    task automatic t_compact();
        do_reset(1'b1);
        send_chk(16'h0000, 2'd0, 16'h0000, 32'hA5A5_5A5A);  // R6
        send_chk(16'h000F, 2'd1, 16'h0003, 32'h0F0F_0F0F);  // R4 R5 one chunk
        send_chk(16'h0010, 2'd2, 16'h0004, 32'hCAFE_F00D);  // R7 two chunks
        send_chk(16'h0ABC, 2'd3, 16'h1234, 32'h0000_00FF);  // R4 R5 mid
        send_chk(16'hFFFF, 2'd1, 16'hFFFF, 32'h7777_7777);  // R10 longest
    endtask

    task automatic t_pin_ignored();
        do_reset(1'b1);
        cfg_var_mode = 1'b0;  // R9 change after reset must not matter
        @(negedge clk);
        send_chk(16'h0123, 2'd2, 16'h0021, 32'h1357_9BDF);
        cfg_var_mode = 1'b1;
        do_reset(1'b0);       // R9 new layout only through reset
        cfg_var_mode = 1'b1;
        send_chk(16'h0123, 2'd2, 16'h0021, 32'h2468_ACE0);
    endtask

    task automatic t_back_to_back();
        do_reset(1'b1);
        for (int i = 0; i < 4; i++) begin
            send_chk(16'(i * 37), 2'(i), 16'(i * 3), 32'(i) * 32'h0101_0101);  // R10 R11
        end
    endtask

    initial begin
        t_uniform();
        t_compact();
        t_pin_ignored();
        t_back_to_back();
        report();
        $finish;
    end

endmodule